// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block runs one conversion-and-readout cycle of a serial successive-approximation converter. A start request pulls a combined select/convert strobe low and then produces a serial clock from a divider of the system clock. From the converter's data line it collects a 14-bit result, most significant bit first, followed by two status bits. When the last clock has gone out and the converter signals end of conversion, the block raises the strobe again and shows the result as a parallel sample with a one-cycle valid pulse.

Two mode inputs are taken at start. An edge selector decides where each bit is captured. A burst selector decides whether the frame runs as one continuous run of clocks, as two halves, or as byte-sized bursts. Each pair of bursts is separated by an idle pause. A watchdog limits the busy time. Slow bursts leak charge in the converter and spoil the result, so when the limit is reached the frame is dropped and an error flag is raised.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset the strobe output is high, the serial clock is low, and busy, valid, error, sample and status are all zero.
- R2: A start request seen while not busy drives the strobe low and raises busy at the same clock edge. A start request seen while busy has no effect on the running frame, and a start request never changes the latched mode inputs of a running frame.
- R3: The serial clock idles low and is high only while the strobe is low. Each half period lasts DIV_HALF system cycles. A frame carries 20 rising edges, or 24 in byte mode.
- R4: burst_mode_i is sampled at start. Value 1 splits the clocks into two bursts of 10, and value 2 splits them into three bursts of 8. Each burst boundary adds GAP_CYC extra low cycles. Values 0 and 3 send one unbroken run of 20 clocks.
- R5: With edge_sel_i = 0 a bit is captured at the rising edge that follows each falling edge. With edge_sel_i = 1 it is captured at the next falling edge. The data level before the first falling edge is never captured.
- R6: The first captured bit becomes sample_o[13] and so on down to sample_o[0]. The 15th and 16th captured bits become status_o[1] and status_o[0]. Data after the 16th bit, including the extra byte-mode clocks, is ignored.
- R7: After the final clock, the block waits for the end-of-conversion input to be high. In the cycle after it is seen, the strobe returns high, sample_valid_o is high for exactly one cycle with the new sample and status, and busy falls. Busy therefore lasts 2·N·DIV_HALF + (B−1)·GAP_CYC + 1 cycles when end of conversion is already high at the final clock, where N is the clock count and B the burst count.
- R8: If busy has lasted LIMIT_CYC cycles, busy falls, the strobe goes high, the serial clock goes low and error_o goes high. No valid pulse is given and the sample and status are left unchanged. error_o stays high until the next accepted start clears it.
- R9: sample_valid_o and error_o are never high together, and sample_o changes only in a cycle where sample_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a conversion |
| edge_sel_i | input | 1 | Capture edge: 0 rising, 1 falling |
| burst_mode_i | input | 2 | 0/3 continuous, 1 two bursts, 2 byte bursts |
| adc_cs_n_o | output | 1 | Combined select/convert strobe, active low |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| adc_dout_i | input | 1 | Serial data from the converter |
| adc_eoc_i | input | 1 | End of conversion from the converter, active high |
| sample_o | output | RES_W | Last good result |
| status_o | output | STAT_W | Status bits of the last good result |
| sample_valid_o | output | 1 | One-cycle pulse on a new result |
| busy_o | output | 1 | Frame in progress |
| error_o | output | 1 | Last frame exceeded the time limit |

## Verification
The assertions assume that the data and end-of-conversion inputs are synchronous to the system clock. They also assume the converter changes its data only after the serial clock falls. The bench meets this with a converter model that updates its data line 2 ns after each falling serial edge and raises end of conversion after the 20th falling edge. It lowers end of conversion when the strobe rises and puts the previous frame's top bit back on the data line. Start pulses and mode changes are driven half a cycle away from the sampling edge. Patterns are chosen so that each frame's top bit differs from the one before it, so a capture of the stale level shows up as a wrong result.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_LOW  = 3'd1,
        SQ_HIGH = 3'd2,
        SQ_GAP  = 3'd3,
        SQ_TAIL = 3'd4
    } seq_state_e;

    localparam logic [1:0] BM_SINGLE = 2'd0;
    localparam logic [1:0] BM_HALVES = 2'd1;
    localparam logic [1:0] BM_BYTES  = 2'd2;

endpackage

// File: rtl/adc_rd_watchdog.sv
`timescale 1ns/1ps
module adc_rd_watchdog #(
    parameter int LIMIT_CYC = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int LW = $clog2(LIMIT_CYC + 1);

    logic [LW-1:0] cnt_d, cnt_q;

    assign expire_o = run_i && (cnt_q == LW'(LIMIT_CYC - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i && !expire_o) begin
            cnt_d = cnt_q + LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_rd_capture.sv
`timescale 1ns/1ps
module adc_rd_capture #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              take_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int NW = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [NW-1:0]     n;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (clear_i) begin
            cap_d.sh = '0;
            cap_d.n  = '0;
        end else if (take_i && (cap_q.n < NW'(WORD_W))) begin
            cap_d.sh = {cap_q.sh[WORD_W-2:0], bit_i};
            cap_d.n  = cap_q.n + NW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign word_o = cap_q.sh;
endmodule

// File: rtl/adc_rd_sequencer.sv
`timescale 1ns/1ps
module adc_rd_sequencer
    import adc_rd_pkg::*;
#(
    parameter int DIV_HALF  = 4,
    parameter int GAP_CYC   = 16,
    parameter int FRAME_CLK = 20,
    parameter int BYTE_W    = 8,
    localparam int BYTE_TOTAL = ((FRAME_CLK + BYTE_W - 1) / BYTE_W) * BYTE_W,
    localparam int CW         = $clog2(BYTE_TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [1:0]    mode_i,
    input  logic          stop_i,
    output logic          cs_n_o,
    output logic          sclk_o,
    output logic          rise_o,
    output logic          fall_o,
    output logic [CW-1:0] falls_o,
    output logic          tail_o
);
    localparam int HALF_SPLIT = FRAME_CLK / 2;
    localparam int DLY_MAX    = (DIV_HALF > GAP_CYC) ? DIV_HALF : GAP_CYC;
    localparam int TW         = $clog2(DLY_MAX + 1);
    localparam bit HAS_GAP    = (GAP_CYC > 0);

    typedef struct packed {
        seq_state_e    st;
        logic [1:0]    mode;
        logic [TW-1:0] tick;
        logic [CW-1:0] falls;
        logic [CW-1:0] bcnt;
        logic          sclk;
        logic          cs_n;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic [CW-1:0] total, burst, next_falls;
    logic          half_end, gap_end;

    always_comb begin
        seq_d  = seq_q;
        rise_o = 1'b0;
        fall_o = 1'b0;

        total = (seq_q.mode == BM_BYTES) ? CW'(BYTE_TOTAL) : CW'(FRAME_CLK);
        case (seq_q.mode)
            BM_HALVES: burst = CW'(HALF_SPLIT);
            BM_BYTES:  burst = CW'(BYTE_W);
            default:   burst = CW'(FRAME_CLK);
        endcase
        next_falls = seq_q.falls + CW'(1);
        half_end   = (seq_q.tick == TW'(DIV_HALF - 1));
        gap_end    = (seq_q.tick == TW'(GAP_CYC - 1));

        case (seq_q.st)
            SQ_IDLE: begin
                if (go_i) begin
                    seq_d.st    = SQ_LOW;
                    seq_d.mode  = mode_i;
                    seq_d.tick  = '0;
                    seq_d.falls = '0;
                    seq_d.bcnt  = '0;
                    seq_d.cs_n  = 1'b0;
                    seq_d.sclk  = 1'b0;
                end
            end
            SQ_LOW: begin
                if (half_end) begin
                    seq_d.tick = '0;
                    seq_d.sclk = 1'b1;
                    seq_d.st   = SQ_HIGH;
                    rise_o     = 1'b1;
                end else begin
                    seq_d.tick = seq_q.tick + TW'(1);
                end
            end
            SQ_HIGH: begin
                if (half_end) begin
                    seq_d.tick  = '0;
                    seq_d.sclk  = 1'b0;
                    seq_d.falls = next_falls;
                    fall_o      = 1'b1;
                    if (next_falls == total) begin
                        seq_d.st = SQ_TAIL;
                    end else if (seq_q.bcnt + CW'(1) == burst) begin
                        seq_d.bcnt = '0;
                        seq_d.st   = HAS_GAP ? SQ_GAP : SQ_LOW;
                    end else begin
                        seq_d.bcnt = seq_q.bcnt + CW'(1);
                        seq_d.st   = SQ_LOW;
                    end
                end else begin
                    seq_d.tick = seq_q.tick + TW'(1);
                end
            end
            SQ_GAP: begin
                if (gap_end) begin
                    seq_d.tick = '0;
                    seq_d.st   = SQ_LOW;
                end else begin
                    seq_d.tick = seq_q.tick + TW'(1);
                end
            end
            SQ_TAIL: begin
                seq_d = seq_q;
            end
            default: begin
                seq_d.st = SQ_IDLE;
            end
        endcase

        if (stop_i) begin
            seq_d.st   = SQ_IDLE;
            seq_d.cs_n = 1'b1;
            seq_d.sclk = 1'b0;
            seq_d.tick = '0;
            rise_o     = 1'b0;
            fall_o     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= SQ_IDLE;
            seq_q.cs_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cs_n_o  = seq_q.cs_n;
    assign sclk_o  = seq_q.sclk;
    assign falls_o = seq_q.falls;
    assign tail_o  = (seq_q.st == SQ_TAIL);
endmodule

// File: rtl/adc_serial_reader.sv
`timescale 1ns/1ps
module adc_serial_reader #(
    parameter int RES_W     = 14,
    parameter int STAT_W    = 2,
    parameter int FRAME_CLK = 20,
    parameter int BYTE_W    = 8,
    parameter int DIV_HALF  = 4,
    parameter int GAP_CYC   = 16,
    parameter int LIMIT_CYC = 2_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              edge_sel_i,
    input  logic [1:0]        burst_mode_i,
    output logic              adc_cs_n_o,
    output logic              adc_sclk_o,
    input  logic              adc_dout_i,
    input  logic              adc_eoc_i,
    output logic [RES_W-1:0]  sample_o,
    output logic [STAT_W-1:0] status_o,
    output logic              sample_valid_o,
    output logic              busy_o,
    output logic              error_o
);
    localparam int WORD_W     = RES_W + STAT_W;
    localparam int BYTE_TOTAL = ((FRAME_CLK + BYTE_W - 1) / BYTE_W) * BYTE_W;
    localparam int CW         = $clog2(BYTE_TOTAL + 1);

    typedef struct packed {
        logic              busy;
        logic              err;
        logic              valid;
        logic              edge_sel;
        logic [RES_W-1:0]  sample;
        logic [STAT_W-1:0] status;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              go, expire, finish, stop, take;
    logic              rise_ev, fall_ev, tail;
    logic [CW-1:0]     falls;
    logic [WORD_W-1:0] word;

    assign go     = start_i && !ctl_q.busy;
    assign finish = tail && adc_eoc_i && !expire;
    assign stop   = expire || finish;
    assign take   = ctl_q.busy && (falls != '0)
                    && (ctl_q.edge_sel ? fall_ev : rise_ev);

    adc_rd_sequencer #(
        .DIV_HALF (DIV_HALF),
        .GAP_CYC  (GAP_CYC),
        .FRAME_CLK(FRAME_CLK),
        .BYTE_W   (BYTE_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .mode_i (burst_mode_i),
        .stop_i (stop),
        .cs_n_o (adc_cs_n_o),
        .sclk_o (adc_sclk_o),
        .rise_o (rise_ev),
        .fall_o (fall_ev),
        .falls_o(falls),
        .tail_o (tail)
    );

    adc_rd_capture #(
        .WORD_W(WORD_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(go),
        .take_i (take),
        .bit_i  (adc_dout_i),
        .word_o (word)
    );

    adc_rd_watchdog #(
        .LIMIT_CYC(LIMIT_CYC)
    ) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (go),
        .run_i   (ctl_q.busy),
        .expire_o(expire)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        if (go) begin
            ctl_d.busy     = 1'b1;
            ctl_d.err      = 1'b0;
            ctl_d.edge_sel = edge_sel_i;
        end else if (expire) begin
            ctl_d.busy = 1'b0;
            ctl_d.err  = 1'b1;
        end else if (finish) begin
            ctl_d.busy   = 1'b0;
            ctl_d.valid  = 1'b1;
            ctl_d.sample = word[WORD_W-1 -: RES_W];
            ctl_d.status = word[STAT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sample_o       = ctl_q.sample;
    assign status_o       = ctl_q.status;
    assign sample_valid_o = ctl_q.valid;
    assign busy_o         = ctl_q.busy;
    assign error_o        = ctl_q.err;
endmodule

// File: rtl/adc_rd_checker.sv
`timescale 1ns/1ps
module adc_rd_checker #(
    parameter int RES_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_cs_n_o,
    input logic             adc_sclk_o,
    input logic [RES_W-1:0] sample_o,
    input logic             sample_valid_o,
    input logic             busy_o,
    input logic             error_o
);
    // R2: strobe stays high whenever no frame is running
    assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> adc_cs_n_o);

    // R2: busy and the strobe begin a frame at the same edge
    assert_start_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $fell(adc_cs_n_o));

    // R3: serial clock is high only inside a selected frame
    assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sclk_o |-> !adc_cs_n_o);

    // R7: valid is a single-cycle pulse
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |=> !sample_valid_o);

    // R7: valid appears as busy ends
    assert_valid_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |-> (!busy_o && $past(busy_o)));

    // R8: an error never coexists with a running frame
    assert_error_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> !busy_o);

    // R9: valid and error are exclusive
    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_valid_o && error_o));

    // R9: the sample register moves only with a valid pulse
    assert_sample_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_o) |-> sample_valid_o);
endmodule

bind adc_serial_reader adc_rd_checker #(.RES_W(RES_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .adc_cs_n_o    (adc_cs_n_o),
    .adc_sclk_o    (adc_sclk_o),
    .sample_o      (sample_o),
    .sample_valid_o(sample_valid_o),
    .busy_o        (busy_o),
    .error_o       (error_o)
);

// File: tb/adc_serial_reader_test.sv
`timescale 1ns/1ps
module adc_serial_reader_test;
    localparam int DIV   = 2;
    localparam int GAP   = 6;
    localparam int LIMIT = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        edge_sel = 1'b0;
    logic [1:0]  burst = 2'd0;
    logic        cs_n, sclk;
    logic        dout = 1'b1;
    logic        eoc = 1'b0;
    logic [13:0] sample;
    logic [1:0]  status;
    logic        valid, busy, err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_serial_reader #(
        .DIV_HALF (DIV),
        .GAP_CYC  (GAP),
        .LIMIT_CYC(LIMIT)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .edge_sel_i    (edge_sel),
        .burst_mode_i  (burst),
        .adc_cs_n_o    (cs_n),
        .adc_sclk_o    (sclk),
        .adc_dout_i    (dout),
        .adc_eoc_i     (eoc),
        .sample_o      (sample),
        .status_o      (status),
        .sample_valid_o(valid),
        .busy_o        (busy),
        .error_o       (err)
    );

    // converter model
    logic [15:0] word_now = 16'h8000;
    logic [15:0] adc_sh = '0;
    bit          eoc_en = 1'b1;
    int          fall_n = 0;
    int          rises = 0;

    always @(negedge cs_n) begin
        adc_sh = word_now;
        fall_n = 0;
    end
    always @(negedge sclk) begin
        fall_n = fall_n + 1;
        #2;
        dout   = adc_sh[15];
        adc_sh = {adc_sh[14:0], 1'b0};
        if (fall_n >= 20 && eoc_en) eoc = 1'b1;
    end
    always @(posedge cs_n) begin
        #2;
        eoc  = 1'b0;
        dout = word_now[15];
    end
    always @(posedge sclk) rises = rises + 1;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic frame(input bit es, input logic [1:0] bm, input logic [13:0] val,
                         input logic [1:0] st, input bit good, input bit poke);
        int busy_len = 0;
        int vcnt = 0;
        int nclk;
        int nb;
        int exp_len;
        logic [13:0] old_s;
        logic [1:0]  old_t;
        old_s    = sample;
        old_t    = status;
        word_now = {val, st};
        eoc_en   = good;
        rises    = 0;
        nclk = (bm == 2'd2) ? 24 : 20;
        nb   = (bm == 2'd1) ? 2 : ((bm == 2'd2) ? 3 : 1);
        exp_len = good ? (2 * nclk * DIV + (nb - 1) * GAP + 1) : LIMIT;
        @(negedge clk);
        start = 1'b1; edge_sel = es; burst = bm;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", busy, 1);
        chk("R2 strobe low after start", cs_n, 0);
        chk("R8 error cleared by start", err, 0);
        for (int g = 0; g < 4000; g++) begin
            if (busy) busy_len++;
            if (valid) vcnt++;
            if (!busy) break;
            @(negedge clk);
            start = 1'b0;
            if (poke && busy_len == 30) begin
                start = 1'b1; edge_sel = ~es; burst = bm + 2'd1;
            end
        end
        edge_sel = es; burst = bm;
        chk("R3 rising edges per frame", rises, nclk);
        chk("R7 strobe high at end", cs_n, 1);
        if (good) begin
            chk("R4 R7 busy length", busy_len, exp_len);
            chk("R7 one valid pulse", vcnt, 1);
            chk("R5 R6 sample", sample, val);
            chk("R6 status", status, st);
            chk("R8 no error", err, 0);
        end else begin
            chk("R8 busy length to timeout", busy_len, exp_len);
            chk("R8 no valid", vcnt, 0);
            chk("R8 error flag", err, 1);
            chk("R8 sample kept", sample, old_s);
            chk("R8 status kept", status, old_t);
            @(negedge clk);
            @(negedge clk);
            chk("R8 error held", err, 1);
            chk("R3 sclk idle low", sclk, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 strobe", cs_n, 1);
        chk("R1 sclk", sclk, 0);
        chk("R1 busy", busy, 0);
        chk("R1 valid", valid, 0);
        chk("R1 error", err, 0);
        chk("R1 sample", sample, 0);
        chk("R1 status", status, 0);

        for (int e = 0; e < 2; e++) begin
            for (int m = 0; m < 4; m++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [13:0] v;
                    logic [1:0]  s;
                    v = 14'((e * 4 + m) * 977 + p * 3251);
                    v[13] = p[0];           // alternate top bit across frames (R5)
                    s = 2'(p + m);
                    frame(e[0], 2'(m), v, s, 1'b1, (p == 1));
                end
            end
        end

        // R8 timeout: end of conversion never arrives
        frame(1'b0, 2'd2, 14'h1234, 2'b10, 1'b0, 1'b0);
        frame(1'b1, 2'd1, 14'h2ABC, 2'b01, 1'b1, 1'b0);
        frame(1'b0, 2'd0, 14'h0F0F, 2'b11, 1'b0, 1'b0);
        frame(1'b0, 2'd0, 14'h3C3C, 2'b00, 1'b1, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule